// File: doc/BRIEF.md
# Clock Synthesizer Control Register

This block is the software-visible control point for an on-chip frequency synthesizer. A single write port loads a packed word holding the feedback multiplier code, the input divider code, a loop-filter code, a power-enable bit and a clock-source select bit. The block decodes the packed divider codes into the true multiplier and divider values that the analog loop consumes. It drives the power request and the select line of an external glitch-aware clock mux.

The analog side reports lock on an input pin. The block keeps a sticky lock flag derived from it. Firmware is expected to follow a fixed sequence: program the dividers, power up, poll for lock, then switch the core over to the synthesized clock. The block polices that sequence. It refuses to switch to the synthesized clock without lock and refuses divider changes while that clock is in use. It raises a configuration-error flag whenever a write breaks a rule or asks for a multiplier/divider ratio that the loop cannot run. Reading the register returns the stored fields plus the two status flags.

Top module: `clkSynthCtrl`

## Requirements
- R1: After reset every field and flag is zero: `rdData` reads 0, `pwrEn`, `selOut` and `lockFlag` are 0, and `mValue`/`nValue` show the decodes of code 0, which are 2 and 2.
- R2: The register word is laid out as multiplier code [4:0], divider code [7:5], loop-filter code [11:8], enable [12], select [13], lock status [14] and error status [15]. Bits [15:14] are read-only, and values written to them have no effect on what is read back.
- R3: `mValue` equals the stored 5-bit multiplier code plus 2.
- R4: `nValue` equals the stored 3-bit divider code plus 2, except that code 3'b111 decodes to 1.
- R5: `pwrEn` follows the stored enable bit and changes on the clock edge that takes the write.
- R6: While enable is 1 and no write occurs, a high `lockIn` sets `lockFlag` on the next edge. The flag then stays set after `lockIn` falls.
- R7: The edge that takes any write clears `lockFlag`. While enable is 0, `lockFlag` stays 0 whatever `lockIn` does.
- R8: A write that sets select while select is 0 and `lockFlag` is 0 is rejected. `selOut` stays 0 and the error flag is set.
- R9: A write that sets select while `lockFlag` is 1 drives `selOut` high on that write's edge. A write with select 0 drives it low.
- R10: While select is 1, a write whose multiplier or divider code differs from the stored one leaves both codes unchanged and sets the error flag. The loop-filter, enable and select fields of that write are still stored.
- R11: A write that leaves multiplier value M below 2·N, or M above 20, sets the error flag. The codes are still stored.
- R12: Each write recomputes the error flag from that write alone. A write breaking no rule clears it, and the flag holds between writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 16 | Write word |
| rdData | output | 16 | Read-back word, fields plus status |
| lockIn | input | 1 | Lock indication from the analog loop |
| pwrEn | output | 1 | Power-up request to the loop |
| selOut | output | 1 | Clock mux select, 1 = synthesized clock |
| mValue | output | 6 | Decoded multiplier value |
| nValue | output | 4 | Decoded divider value |
| lfCode | output | 4 | Loop-filter code to the loop |
| lockFlag | output | 1 | Sticky lock status |
| cfgErr | output | 1 | Configuration-error flag |

## Verification
A wrong stored code shows on `mValue`, `nValue` and `rdData` on the edge after the write. A wrong lock or select state shows on `lockFlag` or `selOut` within one edge of the event that should have changed it. Because the bench compares every output to a behavioural model on every cycle, a bad decision on any write shows up one cycle after that write. That includes a rejected select, a frozen divider or a wrong error value. Directed writes cover each rule in isolation. A long random stretch with a toggling lock input covers the combinations of rules.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  // Strobes from the write-policy control to the register datapath.
  typedef struct packed {
    logic ldDiv;    // take the new multiplier/divider codes
    logic ldRest;   // take loop-filter and enable fields
    logic setSel;   // select goes (or stays) high
    logic clrSel;   // select goes low
    logic clrLock;  // any write clears the sticky lock flag
  } synthStrobeT;

  // Multiplier code is value minus 2.
  function automatic int unsigned decodeMult(input int unsigned code);
    return code + 2;
  endfunction

  // Divider code is value minus 2, with the all-ones code meaning 1.
  function automatic int unsigned decodeDiv(input int unsigned code,
                                            input int unsigned codeWidth);
    if (code == (32'd1 << codeWidth) - 1) return 1;
    return code + 2;
  endfunction

endpackage

// File: rtl/synthCtrl.sv
module synthCtrl
  import clk_synth_pkg::*;
#(
  parameter int MW   = 5,
  parameter int NW   = 3,
  parameter int MMAX = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [MW-1:0] wrM,
  input  logic [NW-1:0] wrN,
  input  logic          wrSel,
  input  logic [MW-1:0] curM,
  input  logic [NW-1:0] curN,
  input  logic          curSel,
  input  logic          lockFlag,
  output synthStrobeT   strobe,
  output logic          cfgErr
);

  logic          divChange;
  logic          divReject;
  logic          selReject;
  logic [MW-1:0] effM;
  logic [NW-1:0] effN;
  logic [31:0]   effMVal;
  logic [31:0]   effNVal;
  logic          ratioBad;
  logic          rangeBad;
  logic          errNext;

  always_comb begin
    divChange = (wrM != curM) || (wrN != curN);
    divReject = curSel && divChange;
    selReject = wrSel && !curSel && !lockFlag;
    effM      = divReject ? curM : wrM;
    effN      = divReject ? curN : wrN;
    effMVal   = decodeMult(32'(effM));
    effNVal   = decodeDiv(32'(effN), NW);
    ratioBad  = effMVal < (effNVal << 1);
    rangeBad  = effMVal > MMAX;
    errNext   = divReject || selReject || ratioBad || rangeBad;
  end

  always_comb begin
    strobe.ldDiv   = wrEn && !divReject;
    strobe.ldRest  = wrEn;
    strobe.setSel  = wrEn && wrSel && !selReject;
    strobe.clrSel  = wrEn && !wrSel;
    strobe.clrLock = wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgErr <= 1'b0;
    else if (wrEn) cfgErr <= errNext;
  end

  // R8: an unlocked select attempt leaves the mux on the input clock and flags it
  a_r8_sel_without_lock: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrSel && !curSel && !lockFlag |=> cfgErr && !curSel);

  // R10: a divider change while selected is flagged
  a_r10_div_change_flagged: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && curSel && (wrM != curM) |=> cfgErr);

  // R12: error flag only moves on writes
  a_r12_err_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfgErr));

endmodule

// File: rtl/synthRegs.sv
module synthRegs
  import clk_synth_pkg::*;
#(
  parameter int MW  = 5,
  parameter int NW  = 3,
  parameter int LFW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  synthStrobeT    strobe,
  input  logic [MW-1:0]  wrM,
  input  logic [NW-1:0]  wrN,
  input  logic [LFW-1:0] wrLf,
  input  logic           wrEnable,
  input  logic           lockIn,
  output logic [MW-1:0]  mCodeQ,
  output logic [NW-1:0]  nCodeQ,
  output logic [LFW-1:0] lfQ,
  output logic           enQ,
  output logic           selQ,
  output logic           lockQ,
  output logic [MW:0]    mValue,
  output logic [NW:0]    nValue
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCodeQ <= '0;
      nCodeQ <= '0;
    end else if (strobe.ldDiv) begin
      mCodeQ <= wrM;
      nCodeQ <= wrN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfQ <= '0;
      enQ <= 1'b0;
    end else if (strobe.ldRest) begin
      lfQ <= wrLf;
      enQ <= wrEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              selQ <= 1'b0;
    else if (strobe.setSel) selQ <= 1'b1;
    else if (strobe.clrSel) selQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockQ <= 1'b0;
    else if (strobe.clrLock) lockQ <= 1'b0;
    else if (!enQ)           lockQ <= 1'b0;
    else if (lockIn)         lockQ <= 1'b1;
  end

  always_comb begin
    mValue = {1'b0, mCodeQ} + (MW+1)'(2);
    if (&nCodeQ) nValue = (NW+1)'(1);
    else         nValue = {1'b0, nCodeQ} + (NW+1)'(2);
  end

  // R7: a powered-down loop never reports lock
  a_r7_no_lock_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !lockQ);

  // R7: the edge taking a write leaves lock clear
  a_r7_write_clears_lock: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLock |=> !lockQ);

  // R9: the mux only moves to the synthesized clock after lock was seen
  a_r9_sel_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selQ) |-> $past(lockQ));

  // R10: divider codes frozen while the synthesized clock is selected
  a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(selQ) |-> $stable(mCodeQ) && $stable(nCodeQ));

  // R6: powered loop with lock and no write sets the flag
  a_r6_lock_sets: assert property (@(posedge clk) disable iff (!rstN)
    enQ && lockIn && !strobe.clrLock |=> lockQ);

endmodule

// File: rtl/clkSynthCtrl.sv
module clkSynthCtrl
  import clk_synth_pkg::*;
#(
  parameter int MW   = 5,
  parameter int NW   = 3,
  parameter int LFW  = 4,
  parameter int MMAX = 20,
  localparam int N_LSB    = MW,
  localparam int LF_LSB   = MW + NW,
  localparam int EN_BIT   = LF_LSB + LFW,
  localparam int SEL_BIT  = EN_BIT + 1,
  localparam int LOCK_BIT = SEL_BIT + 1,
  localparam int ERR_BIT  = LOCK_BIT + 1,
  localparam int REG_W    = ERR_BIT + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             lockIn,
  output logic             pwrEn,
  output logic             selOut,
  output logic [MW:0]      mValue,
  output logic [NW:0]      nValue,
  output logic [LFW-1:0]   lfCode,
  output logic             lockFlag,
  output logic             cfgErr
);

  synthStrobeT    strobe;
  logic [MW-1:0]  mCodeQ;
  logic [NW-1:0]  nCodeQ;
  logic [LFW-1:0] lfQ;
  logic           enQ;
  logic           selQ;
  logic           lockQ;
  logic           errQ;
  logic           unusedStatusBits;

  assign unusedStatusBits = ^wrData[ERR_BIT:LOCK_BIT];

  synthCtrl #(.MW(MW), .NW(NW), .MMAX(MMAX)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrM      (wrData[N_LSB-1:0]),
    .wrN      (wrData[LF_LSB-1:N_LSB]),
    .wrSel    (wrData[SEL_BIT]),
    .curM     (mCodeQ),
    .curN     (nCodeQ),
    .curSel   (selQ),
    .lockFlag (lockQ),
    .strobe   (strobe),
    .cfgErr   (errQ)
  );

  synthRegs #(.MW(MW), .NW(NW), .LFW(LFW)) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrM      (wrData[N_LSB-1:0]),
    .wrN      (wrData[LF_LSB-1:N_LSB]),
    .wrLf     (wrData[EN_BIT-1:LF_LSB]),
    .wrEnable (wrData[EN_BIT]),
    .lockIn   (lockIn),
    .mCodeQ   (mCodeQ),
    .nCodeQ   (nCodeQ),
    .lfQ      (lfQ),
    .enQ      (enQ),
    .selQ     (selQ),
    .lockQ    (lockQ),
    .mValue   (mValue),
    .nValue   (nValue)
  );

  assign rdData   = {errQ, lockQ, selQ, enQ, lfQ, nCodeQ, mCodeQ};
  assign pwrEn    = enQ;
  assign selOut   = selQ;
  assign lfCode   = lfQ;
  assign lockFlag = lockQ;
  assign cfgErr   = errQ;

endmodule

// File: tb/clkSynthCtrl_test.sv
`timescale 1ns/1ps
module clkSynthCtrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        lockIn = 1'b0;
  logic [15:0] rdData;
  logic        pwrEn, selOut, lockFlag, cfgErr;
  logic [5:0]  mValue;
  logic [3:0]  nValue;
  logic [3:0]  lfCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit modelOn = 1'b0;

  // behavioural reference state
  int mC = 0, nC = 0, lf = 0, en = 0, sel = 0, lock = 0, err = 0;

  always #2 clk = ~clk;

  clkSynthCtrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lockIn(lockIn), .pwrEn(pwrEn), .selOut(selOut), .mValue(mValue),
    .nValue(nValue), .lfCode(lfCode), .lockFlag(lockFlag), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int decN(input int c);
    return (c == 7) ? 1 : c + 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mC = 0; nC = 0; lf = 0; en = 0; sel = 0; lock = 0; err = 0;
    end else if (wrEn) begin
      int wm, wn, wantSel, divRej, selRej, mv, nv;
      wm = int'(wrData[4:0]);
      wn = int'(wrData[7:5]);
      wantSel = int'(wrData[13]);
      divRej = (sel == 1 && (wm != mC || wn != nC)) ? 1 : 0;
      selRej = (wantSel == 1 && sel == 0 && lock == 0) ? 1 : 0;
      if (divRej == 0) begin mC = wm; nC = wn; end
      lf = int'(wrData[11:8]);
      en = int'(wrData[12]);
      if (wantSel == 0) sel = 0;
      else if (selRej == 0) sel = 1;
      mv = mC + 2;
      nv = decN(nC);
      err = (divRej == 1 || selRej == 1 || mv < 2 * nv || mv > 20) ? 1 : 0;
      lock = 0;
    end else if (en == 0) begin
      lock = 0;
    end else if (lockIn) begin
      lock = 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      int expRd;
      expRd = (err << 15) | (lock << 14) | (sel << 13) | (en << 12) | (lf << 8) | (nC << 5) | mC;
      chk("R2 rdData", int'(rdData), expRd);
      chk("R3 mValue", int'(mValue), mC + 2);
      chk("R4 nValue", int'(nValue), decN(nC));
      chk("R5 pwrEn", int'(pwrEn), en);
      chk("R6 lockFlag", int'(lockFlag), lock);
      chk("R9 selOut", int'(selOut), sel);
      chk("R12 cfgErr", int'(cfgErr), err);
      chk("R2 lfCode", int'(lfCode), lf);
    end
  end

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdData", int'(rdData), 0);
    chk("R1 selOut", int'(selOut), 0);
    chk("R1 pwrEn", int'(pwrEn), 0);
    chk("R1 lockFlag", int'(lockFlag), 0);
    chk("R1 mValue", int'(mValue), 2);
    chk("R1 nValue", int'(nValue), 2);
    rstN = 1'b1;
    modelOn = 1'b1;

    doWrite(16'h1006);                       // en, M=8, N=2
    chk("R3 M=8", int'(mValue), 8);
    chk("R5 pwrEn up", int'(pwrEn), 1);
    chk("R11 legal ratio", int'(cfgErr), 0);
    lockIn = 1'b1;
    @(negedge clk);
    chk("R6 lock set", int'(lockFlag), 1);
    lockIn = 1'b0;
    @(negedge clk);
    chk("R6 lock held", int'(lockFlag), 1);

    doWrite(16'h3006);                       // select with lock
    chk("R9 selOut high", int'(selOut), 1);
    chk("R7 write clears lock", int'(lockFlag), 0);

    doWrite(16'h3507);                       // divider change while selected
    chk("R10 M frozen", int'(mValue), 8);
    chk("R10 err", int'(cfgErr), 1);
    chk("R10 lf stored", int'(rdData[11:8]), 5);

    doWrite(16'h1006);                       // deselect, legal
    chk("R9 selOut low", int'(selOut), 0);
    chk("R12 err cleared", int'(cfgErr), 0);

    doWrite(16'h3006);                       // select without lock
    chk("R8 sel rejected", int'(selOut), 0);
    chk("R8 err", int'(cfgErr), 1);

    doWrite(16'h1001);                       // M=3, N=2
    chk("R11 ratio err", int'(cfgErr), 1);
    chk("R11 M stored", int'(mValue), 3);

    doWrite(16'h10E0);                       // M=2, N=1
    chk("R4 N=1", int'(nValue), 1);
    chk("R11 ratio 2 ok", int'(cfgErr), 0);

    doWrite(16'h1013);                       // M=21
    chk("R11 range err", int'(cfgErr), 1);

    lockIn = 1'b1;
    doWrite(16'hC006);                       // power down, status bits written high
    chk("R2 status bits ignored", int'(rdData[15:14]), 0);
    chk("R5 pwrEn down", int'(pwrEn), 0);
    repeat (2) @(negedge clk);
    chk("R7 no lock while off", int'(lockFlag), 0);
    lockIn = 1'b0;

    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      lockIn = ($urandom % 3) == 0;
      wrEn   = ($urandom % 4) == 0;
      wrData = 16'($urandom);
      if ($urandom % 2 == 0) wrData[12] = 1'b1;
    end
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule